// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Engine

This engine takes frames from a byte-wide stream and scatters them across a circular ring of receive descriptors held in system memory. Each descriptor is four 32-bit words at consecutive addresses: a control/status word, a size word, a buffer address and a link address. When a frame begins, the engine walks the ring from its current pointer. It looks for a descriptor that hardware owns and whose buffer holds at least 64 bytes. It then packs stream bytes into words and writes them to that buffer. When a descriptor is finished, the engine writes back its status word with first/last markers and a length.

All memory traffic uses one word-wide request/acknowledge port. The engine holds the stream's ready low while it searches the ring or writes a descriptor back. Two sticky interrupt status bits report a completed descriptor and a lack of usable descriptors. A small control word carries a run bit, which the engine clears when it has finished with a frame.

The controller is one state machine with these states: `ST_IDLE` waits for a frame. `ST_SEEK` rejects a zero candidate address. `ST_RD_CTRL`, `ST_RD_SIZE`, `ST_RD_BUF` and `ST_RD_LINK` fetch the candidate's words in that order. `ST_PICK` takes or skips the candidate. `ST_FILL` accepts bytes. `ST_FLUSH` writes one packed word. `ST_CLOSE` writes the status word back. `ST_DROP` discards the rest of a frame. `ST_FINISH` clears the run bit.

The transitions are as follows. IDLE goes to SEEK when a frame starts while enabled. SEEK goes to RD_CTRL for a non-zero address, or fails. The reads chain through to PICK. PICK goes to FILL on a usable descriptor. It goes straight to CLOSE when FCS bytes spill over, and to FINISH when the frame is already complete. It returns to SEEK on the link, or fails when the link equals the search start. FILL goes to FLUSH when a word completes, the buffer fills or the last byte arrives. FLUSH goes to CLOSE or back to FILL. CLOSE goes to SEEK from its own link. A failed search goes to DROP, or to FINISH if no bytes remain. DROP goes to FINISH on the last byte, and FINISH goes to IDLE.

Top module: `rx_scatter_engine`

## Requirements
- R1: While `rx_en` is low, a waiting frame is not taken: `s_ready` stays low and no memory request is made.
- R2: A descriptor is usable only when control bit 31 (owned) is set and size-word bits [10:0] are at least 64. The search follows link words and takes the first usable descriptor it finds; unusable descriptors are left unwritten.
- R3: A search fails when the candidate address is zero, or when an unusable descriptor's link equals the address the search started from. A failure sets `sta_nobuf`, sets `cur_desc` to `ring_head` and discards any bytes of the frame not yet taken.
- R4: Frame bytes are packed little-endian, the first byte of a buffer going into byte lane 0 of the word at the buffer address, which must be word aligned. A partial word is written with only its filled byte enables, so the other bytes in memory keep their values.
- R5: A status write-back clears bit 31 and length bits [29:16]. It sets bit 9 on the first descriptor of a frame and bit 8 on the last one, and keeps all other bits.
- R6: A non-last descriptor reports its buffer size as length. A last descriptor holding n bytes reports max(n, 64) + 4, which applies when n + 4 fits in the buffer.
- R7: If the last byte leaves fewer than 4 free bytes, the descriptor is closed as non-last with length equal to its size. The next usable descriptor then receives no data and is closed with bit 8 set and length 68.
- R8: After each status write-back `sta_rx` is set, unless size-word bit 31 (quiet) of that descriptor is set.
- R9: After each write-back, including the last one of a frame, the engine searches from that descriptor's link. `cur_desc` is set to the descriptor found, or the failure rule of R3 applies.
- R10: `ctl1_q` bit 1 always reads 1. Bit 31 is cleared when handling of a frame ends, whether it was stored or dropped.
- R11: `sta_rx` and `sta_nobuf` stay set until a 1 is written to `int_clr` bit 0 or bit 1 respectively.
- R12: `s_ready` is never high while a memory request is pending.
- R13: A memory request keeps its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| ring_head | input | AW | Ring head address, used for loads and rewinds |
| ring_load | input | 1 | Loads `ring_head` into the current pointer while idle |
| ctl1_we | input | 1 | Write strobe for the control word |
| ctl1_wdata | input | 32 | Control word write data (bit 31 = run) |
| ctl1_q | output | 32 | Control word read-back |
| int_clr | input | 2 | Write-1-to-clear: bit 0 rx, bit 1 no-buffer |
| sta_rx | output | 1 | Descriptor-completed status |
| sta_nobuf | output | 1 | No-usable-descriptor status |
| cur_desc | output | AW | Current descriptor pointer |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_last | input | 1 | Last byte of frame |
| s_ready | output | 1 | Engine takes the byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Request completed |

## Verification
The assertions check the rules that hold on every cycle. The stream handshake and memory access never overlap, a pending request keeps its address and direction, no write goes out with empty byte enables, the fixed control bit reads as one, and the status bits stay set until cleared. Only the bench's scenarios can show the rest, which depends on descriptor contents built in memory. That covers the ring walk that skips small or foreign descriptors, the exact status words and lengths with padding and FCS spill, packed buffer contents with untouched neighbours, quiet descriptors, and rewinding the pointer on an exhausted ring.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int OWN_BIT     = 31;
    localparam int QUIET_BIT   = 31;
    localparam int FIRST_BIT   = 9;
    localparam int LAST_BIT    = 8;
    localparam int LEN_LSB     = 16;
    localparam int LEN_W       = 14;
    localparam int SIZE_W      = 11;
    localparam int RUN_BIT     = 31;
    localparam int FIXED_BIT   = 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEEK,
        ST_RD_CTRL,
        ST_RD_SIZE,
        ST_RD_BUF,
        ST_RD_LINK,
        ST_PICK,
        ST_FILL,
        ST_FLUSH,
        ST_CLOSE,
        ST_DROP,
        ST_FINISH
    } rxs_state_e;

endpackage

// File: rtl/rxs_desc_eval.sv
module rxs_desc_eval
    import rxs_pkg::*;
#(
    parameter int CNT_W     = SIZE_W + 1,
    parameter int MIN_FRAME = 64,
    parameter int FCS_BYTES = 4
) (
    input  logic [31:0]      ctl_word,
    input  logic [31:0]      size_word,
    input  logic [CNT_W-1:0] fill_cnt,
    input  logic             first_flag,
    input  logic             eof_flag,
    output logic             usable,
    output logic             quiet,
    output logic             close_last,
    output logic [CNT_W-1:0] buf_bytes,
    output logic [31:0]      status_out
);

    logic [CNT_W-1:0] body;
    logic [LEN_W-1:0] len_val;
    logic [CNT_W:0]   need;

    assign buf_bytes = CNT_W'(size_word[SIZE_W-1:0]);
    assign usable    = ctl_word[OWN_BIT] && (buf_bytes >= CNT_W'(MIN_FRAME));
    assign quiet     = size_word[QUIET_BIT];
    assign need      = {1'b0, fill_cnt} + (CNT_W+1)'(FCS_BYTES);
    assign close_last = eof_flag && (need <= {1'b0, buf_bytes});

    always_comb begin
        body = (fill_cnt < CNT_W'(MIN_FRAME)) ? CNT_W'(MIN_FRAME) : fill_cnt;
        if (close_last) begin
            len_val = LEN_W'(body) + LEN_W'(FCS_BYTES);
        end else begin
            len_val = LEN_W'(buf_bytes);
        end
        status_out                      = ctl_word;
        status_out[OWN_BIT]             = 1'b0;
        status_out[LEN_LSB +: LEN_W]    = len_val;
        status_out[FIRST_BIT]           = ctl_word[FIRST_BIT] | first_flag;
        status_out[LAST_BIT]            = ctl_word[LAST_BIT] | close_last;
    end

endmodule

// File: rtl/rxs_byte_packer.sv
module rxs_byte_packer #(
    parameter int LANES  = 4,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        data,
    output logic [LANES*8-1:0] word,
    output logic [LANES-1:0]  be
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            be   <= '0;
        end else if (clear) begin
            be   <= '0;
        end else if (push) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane == LANE_W'(i)) begin
                    word[i*8 +: 8] <= data;
                    be[i]          <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rx_scatter_engine.sv
module rx_scatter_engine
    import rxs_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MIN_FRAME = 64,
    parameter int FCS_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic [AW-1:0] ring_head,
    input  logic          ring_load,
    input  logic          ctl1_we,
    input  logic [31:0]   ctl1_wdata,
    output logic [31:0]   ctl1_q,
    input  logic [1:0]    int_clr,
    output logic          sta_rx,
    output logic          sta_nobuf,
    output logic [AW-1:0] cur_desc,
    input  logic [7:0]    s_data,
    input  logic          s_valid,
    input  logic          s_last,
    output logic          s_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack
);

    localparam int CNT_W  = SIZE_W + 1;
    localparam int LANES  = 4;
    localparam int LANE_W = $clog2(LANES);

    rxs_state_e state_q, state_d;

    logic [AW-1:0]    cur_q, start_q, cand_q, wr_addr_q;
    logic [31:0]      d_ctl_q, d_size_q;
    logic [AW-1:0]    d_buf_q, d_link_q;
    logic [CNT_W-1:0] cnt_q;
    logic             first_q, eof_q, spill_q;
    logic             sta_rx_q, sta_nobuf_q;
    logic [31:0]      ctl1_r;

    logic             usable, quiet, close_last;
    logic [CNT_W-1:0] buf_bytes;
    logic [31:0]      status_word;
    logic [31:0]      pk_word;
    logic [LANES-1:0] pk_be;

    logic accept, fail_now, word_done, pk_clear;

    rxs_desc_eval #(
        .CNT_W     (CNT_W),
        .MIN_FRAME (MIN_FRAME),
        .FCS_BYTES (FCS_BYTES)
    ) u_eval (
        .ctl_word   (d_ctl_q),
        .size_word  (d_size_q),
        .fill_cnt   (cnt_q),
        .first_flag (first_q),
        .eof_flag   (eof_q),
        .usable     (usable),
        .quiet      (quiet),
        .close_last (close_last),
        .buf_bytes  (buf_bytes),
        .status_out (status_word)
    );

    assign pk_clear = (state_q == ST_PICK) || (state_q == ST_FLUSH && mem_ack);

    rxs_byte_packer #(
        .LANES (LANES)
    ) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pk_clear),
        .push  (state_q == ST_FILL && accept),
        .lane  (cnt_q[LANE_W-1:0]),
        .data  (s_data),
        .word  (pk_word),
        .be    (pk_be)
    );

    assign accept    = s_valid && s_ready;
    assign word_done = (cnt_q[LANE_W-1:0] == LANE_W'(LANES - 1)) || s_last ||
                       (cnt_q + CNT_W'(1) == buf_bytes);
    assign fail_now  = (state_q == ST_SEEK && cand_q == '0) ||
                       (state_q == ST_PICK && !usable && d_link_q == start_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (rx_en && s_valid) state_d = ST_SEEK;
            ST_SEEK:    state_d = (cand_q == '0) ? (eof_q ? ST_FINISH : ST_DROP) : ST_RD_CTRL;
            ST_RD_CTRL: if (mem_ack) state_d = ST_RD_SIZE;
            ST_RD_SIZE: if (mem_ack) state_d = ST_RD_BUF;
            ST_RD_BUF:  if (mem_ack) state_d = ST_RD_LINK;
            ST_RD_LINK: if (mem_ack) state_d = ST_PICK;
            ST_PICK: begin
                if (usable) begin
                    if (spill_q)    state_d = ST_CLOSE;
                    else if (eof_q) state_d = ST_FINISH;
                    else            state_d = ST_FILL;
                end else if (d_link_q == start_q) begin
                    state_d = eof_q ? ST_FINISH : ST_DROP;
                end else begin
                    state_d = ST_SEEK;
                end
            end
            ST_FILL:    if (accept && word_done) state_d = ST_FLUSH;
            ST_FLUSH:   if (mem_ack) state_d = (eof_q || cnt_q == buf_bytes) ? ST_CLOSE : ST_FILL;
            ST_CLOSE:   if (mem_ack) state_d = ST_SEEK;
            ST_DROP:    if (accept && s_last) state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s_ready   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = 4'hF;
        unique case (state_q)
            ST_RD_CTRL: begin mem_req = 1'b1; mem_addr = cand_q; end
            ST_RD_SIZE: begin mem_req = 1'b1; mem_addr = cand_q + AW'(4); end
            ST_RD_BUF:  begin mem_req = 1'b1; mem_addr = cand_q + AW'(8); end
            ST_RD_LINK: begin mem_req = 1'b1; mem_addr = cand_q + AW'(12); end
            ST_FLUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wr_addr_q;
                mem_wdata = pk_word;
                mem_be    = pk_be;
            end
            ST_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q;
                mem_wdata = status_word;
            end
            ST_FILL, ST_DROP: s_ready = 1'b1;
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            start_q     <= '0;
            cand_q      <= '0;
            wr_addr_q   <= '0;
            d_ctl_q     <= '0;
            d_size_q    <= '0;
            d_buf_q     <= '0;
            d_link_q    <= '0;
            cnt_q       <= '0;
            first_q     <= 1'b0;
            eof_q       <= 1'b0;
            spill_q     <= 1'b0;
            sta_rx_q    <= 1'b0;
            sta_nobuf_q <= 1'b0;
            ctl1_r      <= '0;
        end else begin
            sta_rx_q    <= sta_rx_q & ~int_clr[0];
            sta_nobuf_q <= sta_nobuf_q & ~int_clr[1];
            if (ctl1_we) ctl1_r <= ctl1_wdata;

            unique case (state_q)
                ST_IDLE: begin
                    if (ring_load) cur_q <= ring_head;
                    if (rx_en && s_valid) begin
                        start_q <= cur_q;
                        cand_q  <= cur_q;
                        first_q <= 1'b1;
                        eof_q   <= 1'b0;
                        spill_q <= 1'b0;
                    end
                end
                ST_RD_CTRL: if (mem_ack) d_ctl_q  <= mem_rdata;
                ST_RD_SIZE: if (mem_ack) d_size_q <= mem_rdata;
                ST_RD_BUF:  if (mem_ack) d_buf_q  <= AW'(mem_rdata);
                ST_RD_LINK: if (mem_ack) d_link_q <= AW'(mem_rdata);
                ST_PICK: begin
                    if (usable) begin
                        cur_q     <= cand_q;
                        wr_addr_q <= d_buf_q;
                        cnt_q     <= '0;
                    end else begin
                        cand_q <= d_link_q;
                    end
                end
                ST_FILL: begin
                    if (accept) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (s_last) eof_q <= 1'b1;
                    end
                end
                ST_FLUSH: if (mem_ack) wr_addr_q <= wr_addr_q + AW'(4);
                ST_CLOSE: begin
                    if (mem_ack) begin
                        if (!quiet) sta_rx_q <= 1'b1;
                        first_q <= 1'b0;
                        spill_q <= eof_q && !close_last;
                        start_q <= d_link_q;
                        cand_q  <= d_link_q;
                    end
                end
                ST_FINISH: ctl1_r[RUN_BIT] <= 1'b0;
                default: ;
            endcase

            if (fail_now) begin
                sta_nobuf_q <= 1'b1;
                cur_q       <= ring_head;
            end
        end
    end

    assign cur_desc  = cur_q;
    assign sta_rx    = sta_rx_q;
    assign sta_nobuf = sta_nobuf_q;
    assign ctl1_q    = ctl1_r | (32'd1 << FIXED_BIT);

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [31:0]   ctl1_q,
    input logic [1:0]    int_clr,
    input logic          sta_rx,
    input logic          sta_nobuf,
    input logic          s_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    mem_be,
    input logic          mem_ack
);

    p_ready_vs_mem_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_ready && mem_req));

    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_write_has_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != 4'h0));

    p_fixed_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl1_q[1]);

    p_rx_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sta_rx && !int_clr[0]) |=> sta_rx);

    p_nobuf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sta_nobuf && !int_clr[1]) |=> sta_nobuf);

endmodule

bind rx_scatter_engine rxs_checker #(.AW(AW)) u_rxs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl1_q    (ctl1_q),
    .int_clr   (int_clr),
    .sta_rx    (sta_rx),
    .sta_nobuf (sta_nobuf),
    .s_ready   (s_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_ack   (mem_ack)
);

// File: tb/tb_rx_scatter_engine.sv
`timescale 1ns/1ps
module tb_rx_scatter_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic [31:0] ring_head = '0;
    logic        ring_load = 1'b0;
    logic        ctl1_we = 1'b0;
    logic [31:0] ctl1_wdata = '0;
    logic [31:0] ctl1_q;
    logic [1:0]  int_clr = '0;
    logic        sta_rx, sta_nobuf;
    logic [31:0] cur_desc;
    logic [7:0]  s_data = '0;
    logic        s_valid = 1'b0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata;
    logic        mem_ack;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rx_scatter_engine dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_head(ring_head),
        .ring_load(ring_load), .ctl1_we(ctl1_we), .ctl1_wdata(ctl1_wdata),
        .ctl1_q(ctl1_q), .int_clr(int_clr), .sta_rx(sta_rx), .sta_nobuf(sta_nobuf),
        .cur_desc(cur_desc), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
        .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // memory model with a backdoor write path for the bench
    logic [31:0] mem [0:1023];
    logic        bd_we = 1'b0;
    logic [31:0] bd_addr = '0;
    logic [31:0] bd_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < 1024; i++) mem[i] <= 32'hEEEE_EEEE;
        end else begin
            if (bd_we) mem[bd_addr[11:2]] <= bd_data;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
                end else begin
                    mem_rdata <= mem[mem_addr[11:2]];
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    // protocol monitors for R12 and R13
    logic overlap_seen = 1'b0;
    logic hold_broken  = 1'b0;
    logic        prev_pend = 1'b0;
    logic [31:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (s_ready && mem_req) overlap_seen <= 1'b1;
            if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_broken <= 1'b1;
            prev_pend <= mem_req && !mem_ack;
            prev_addr <= mem_addr;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem[a[11:2]];
    endfunction

    task automatic wr_word(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = a; bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic set_desc(input logic [31:0] a, input logic [31:0] ctl,
                            input logic [31:0] size, input logic [31:0] buf_a,
                            input logic [31:0] link);
        wr_word(a, ctl);
        wr_word(a + 4, size);
        wr_word(a + 8, buf_a);
        wr_word(a + 12, link);
    endtask

    task automatic load_head(input logic [31:0] a);
        @(negedge clk);
        ring_head = a; ring_load = 1'b1;
        @(negedge clk);
        ring_load = 1'b0;
    endtask

    task automatic arm_and_clear();
        @(negedge clk);
        ctl1_we = 1'b1; ctl1_wdata = 32'h8000_0000; int_clr = 2'b11;
        @(negedge clk);
        ctl1_we = 1'b0; int_clr = 2'b00;
    endtask

    task automatic send_frame(input int n);
        for (int i = 1; i <= n; i++) begin
            s_data = 8'(i); s_valid = 1'b1; s_last = (i == n);
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
        while (ctl1_q[31]) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 reset ctl1", ctl1_q, 32'h0000_0002);
        chk("R11 reset status", {30'd0, sta_nobuf, sta_rx}, 32'd0);
        chk("R1 reset ready", {31'd0, s_ready}, 32'd0);
        chk("R13 reset req", {31'd0, mem_req}, 32'd0);
        chk("R9 reset pointer", cur_desc, 32'd0);
    endtask

    task automatic t_disabled();
        logic seen = 1'b0;
        rx_en = 1'b0;
        @(negedge clk);
        s_valid = 1'b1; s_data = 8'h55;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (s_ready || mem_req) seen = 1'b1;
        end
        s_valid = 1'b0;
        chk("R1 disabled no take", {31'd0, seen}, 32'd0);
        rx_en = 1'b1;
    endtask

    task automatic t_basic();
        set_desc(32'h100, 32'h8000_0000, 32'd128, 32'h400, 32'h110);
        set_desc(32'h110, 32'h8000_0000, 32'd128, 32'h480, 32'h120);
        set_desc(32'h120, 32'h8000_0000, 32'd128, 32'h500, 32'h100);
        load_head(32'h100);
        arm_and_clear();
        send_frame(10);
        chk("R5 R6 short frame status", rd(32'h100), 32'h0044_0300);
        chk("R4 word0", rd(32'h400), 32'h0403_0201);
        chk("R4 word1", rd(32'h404), 32'h0807_0605);
        chk("R4 partial word", rd(32'h408), 32'hEEEE_0A09);
        chk("R8 rx status", {31'd0, sta_rx}, 32'd1);
        chk("R9 pointer advanced", cur_desc, 32'h110);
        chk("R10 run bit cleared", ctl1_q, 32'h0000_0002);
        chk("R9 no nobuf", {31'd0, sta_nobuf}, 32'd0);
    endtask

    task automatic t_clear();
        @(negedge clk);
        int_clr = 2'b01;
        @(negedge clk);
        int_clr = 2'b00;
        chk("R11 w1c rx", {31'd0, sta_rx}, 32'd0);
    endtask

    task automatic t_multi();
        wr_word(32'h114, 32'd64);
        arm_and_clear();
        send_frame(150);
        chk("R6 non-last length", rd(32'h110), 32'h0040_0200);
        chk("R6 last no padding", rd(32'h120), 32'h005A_0100);
        chk("R4 second buffer", rd(32'h500), 32'h4443_4241);
        chk("R4 first buffer tail", rd(32'h4BC), 32'h403F_3E3D);
        chk("R9 exhausted nobuf", {31'd0, sta_nobuf}, 32'd1);
        chk("R9 rewind to head", cur_desc, 32'h100);
    endtask

    task automatic t_quiet();
        set_desc(32'h200, 32'h8000_0000, 32'h8000_0080, 32'h600, 32'h200);
        load_head(32'h200);
        arm_and_clear();
        send_frame(8);
        chk("R8 quiet no rx", {31'd0, sta_rx}, 32'd0);
        chk("R5 quiet status", rd(32'h200), 32'h0044_0300);
        chk("R3 self loop nobuf", {31'd0, sta_nobuf}, 32'd1);
    endtask

    task automatic t_spill();
        set_desc(32'h300, 32'h8000_0000, 32'd64, 32'h700, 32'h310);
        set_desc(32'h310, 32'h8000_0000, 32'd128, 32'h780, 32'h300);
        load_head(32'h300);
        arm_and_clear();
        send_frame(62);
        chk("R7 spill first", rd(32'h300), 32'h0040_0200);
        chk("R7 spill tail desc", rd(32'h310), 32'h0044_0100);
        chk("R7 tail partial", rd(32'h73C), 32'hEEEE_3E3D);
        chk("R7 no data in tail buf", rd(32'h780), 32'hEEEE_EEEE);
        chk("R8 spill rx", {31'd0, sta_rx}, 32'd1);
    endtask

    task automatic t_skip();
        set_desc(32'h380, 32'h8000_0000, 32'd32, 32'h880, 32'h390);
        set_desc(32'h390, 32'h0000_0000, 32'd128, 32'h900, 32'h3A0);
        set_desc(32'h3A0, 32'h8000_0000, 32'd64, 32'h800, 32'h380);
        load_head(32'h380);
        arm_and_clear();
        send_frame(4);
        chk("R2 usable picked", rd(32'h3A0), 32'h0044_0300);
        chk("R2 small left alone", rd(32'h380), 32'h8000_0000);
        chk("R2 foreign left alone", rd(32'h390), 32'h0000_0000);
        chk("R2 data placed", rd(32'h800), 32'h0403_0201);
    endtask

    task automatic t_nobuf();
        arm_and_clear();
        send_frame(20);
        chk("R3 nobuf set", {31'd0, sta_nobuf}, 32'd1);
        chk("R3 no rx", {31'd0, sta_rx}, 32'd0);
        chk("R3 pointer head", cur_desc, 32'h380);
        chk("R10 drop clears run", ctl1_q, 32'h0000_0002);
        chk("R3 nothing written", rd(32'h880), 32'hEEEE_EEEE);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_basic();
        t_clear();
        t_multi();
        t_quiet();
        t_spill();
        t_skip();
        t_nobuf();
        chk("R12 ready and memory disjoint", {31'd0, overlap_seen}, 32'd0);
        chk("R13 request held to ack", {31'd0, hold_broken}, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule